// File: doc/BRIEF.md
# SPI ADC Command Host

This block is an SPI host that talks to the command port of a delta-sigma ADC from FPGA logic. Every transfer is a 24-bit frame. A 16-bit code sits in the upper 16 bits and the lower 8 bits are zero padding. The host runs CPOL = 0 and CPHA = 1. SCLK idles low. The host changes DIN on each rising SCLK edge, and it samples DOUT on each falling edge, after the device has moved its output on the rising edge.

A user starts an operation with a one-cycle `start` pulse. When `op_custom` is low, the host sends the software reset command 0x0011 (the frame 0x001100). It then sends null frames (0x000000) and collects each answer, because a reply always arrives in the frame after the one that asked for it. The sequence succeeds only when a frame returns exactly 0xFF0200. A ready code with a non-zero pad byte is rejected at once. Any other word counts as not ready yet, until the poll limit runs out. When `op_custom` is high, the host sends `{cmd_code, 8'h00}` and then one null frame, and it returns the upper 16 bits of that frame.

The controller has four states. S_IDLE moves to S_CMD on `start`. S_CMD moves to S_POLL when the command frame ends. S_POLL either stays in S_POLL (it sends another null frame) or moves to S_DONE when a verdict is reached. S_DONE always returns to S_IDLE after one cycle. Beneath the controller, a frame engine moves through F_IDLE, F_LEAD, F_SHIFT, F_TRAIL and F_GAP. Each of these phases is timed by a half-period ticker.

Top module: `adc_cmd_host`

## Requirements
- R1: With `op_custom` = 0, the first frame after `start` carries 0x001100 on DIN, MSB first.
- R2: Every frame after the command frame carries 0x000000 on DIN.
- R3: A reset sequence ends with `ready_ok` = 1 and `error` = 0 only if a poll frame returns exactly 0xFF0200; `resp_code` then reads 0xFF02. `ready_ok` and `error` are never both high.
- R4: A poll frame that returns 0xFF02 in the upper 16 bits with a non-zero low byte ends the sequence at once with `error` = 1 and `ready_ok` = 0.
- R5: Any other poll response leads to another null frame. After `poll_limit` null frames with no match, the sequence ends with `error` = 1. A limit of 0 behaves as 1. The total frame count is 1 + number of polls.
- R6: With `op_custom` = 1, the host sends `{cmd_code, 8'h00}` and then exactly one null frame. `resp_code` is bits 23:8 of the word received in that frame, `ready_ok` = 0, and `error` = 1 exactly when bits 7:0 of that word are non-zero.
- R7: SCLK is low whenever CS_n is high. DIN changes only on a rising SCLK edge or when CS_n rises. DOUT is sampled on falling SCLK edges.
- R8: CS_n goes low at least one half-period before the first SCLK edge and stays low for all 24 bits. It is high for at least one half-period between frames.
- R9: `busy` is high from the cycle after an accepted `start` through the cycle in which `done` is high. `done` is a one-cycle pulse. A `start` that arrives while `busy` is high is ignored.
- R10: Out of reset, `cs_n` = 1, `sclk` = 0, `din` = 0, `busy` = 0, `done` = 0, `ready_ok` = 0, `error` = 0 and `resp_code` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin an operation |
| op_custom | input | 1 | 0: reset-and-ready sequence, 1: single user command |
| cmd_code | input | 16 | User command code for op_custom = 1 |
| poll_limit | input | POLL_W | Maximum null frames while waiting for ready |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| ready_ok | output | 1 | Exact ready response seen |
| error | output | 1 | Bad ready, timeout, or non-zero pad on a user response |
| resp_code | output | 16 | Upper 16 bits of the last response frame |
| sclk | output | 1 | SPI clock, idles low |
| cs_n | output | 1 | Active-low chip select |
| din | output | 1 | Serial data from host to device |
| dout | input | 1 | Serial data from device to host |

## Verification
The hardest cases to reach are a late ready after several not-ready replies and a ready code that differs only in its last pad bit. Both require the device to return a different word in each frame. The bench therefore uses a behavioural device that loads a scripted response into its shift register per frame at the falling edge of CS_n and shifts it out on rising SCLK edges. This lets each table row set up an early match, a late match, a 0xFF0201 reply or a full timeout. The same model also collects DIN on falling edges, so the command word and the null polls are checked exactly as the device would see them.

// File: rtl/adc_cmd_pkg.sv
package adc_cmd_pkg;
    localparam int WORD_W = 24;
    localparam int CODE_W = 16;
    localparam int PAD_W  = WORD_W - CODE_W;
    localparam logic [CODE_W-1:0] RESET_CODE = 16'h0011;
    localparam logic [CODE_W-1:0] READY_CODE = 16'hFF02;

    typedef enum logic [1:0] {
        S_IDLE,
        S_CMD,
        S_POLL,
        S_DONE
    } host_st_t;

    typedef enum logic [2:0] {
        F_IDLE,
        F_LEAD,
        F_SHIFT,
        F_TRAIL,
        F_GAP
    } frame_ph_t;
endpackage

// File: rtl/adc_half_tick.sv
module adc_half_tick #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic tick
);
    localparam int CW = $clog2(HALF + 1);

    logic [CW-1:0] cnt;

    assign tick = active && (cnt == CW'(HALF - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!active || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/adc_frame_engine.sv
module adc_frame_engine
    import adc_cmd_pkg::*;
#(
    parameter int HALF = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              dout,
    output logic              sclk,
    output logic              cs_n,
    output logic              din,
    output logic              fdone,
    output logic [WORD_W-1:0] rx_word
);
    localparam int BW = $clog2(WORD_W);

    frame_ph_t         ph;
    logic [WORD_W-1:0] sh;
    logic [BW-1:0]     bitcnt;
    logic              tick;

    adc_half_tick #(.HALF(HALF)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (ph != F_IDLE),
        .tick   (tick)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph      <= F_IDLE;
            sh      <= '0;
            bitcnt  <= '0;
            sclk    <= 1'b0;
            cs_n    <= 1'b1;
            din     <= 1'b0;
            fdone   <= 1'b0;
            rx_word <= '0;
        end else begin
            fdone <= 1'b0;
            unique case (ph)
                F_IDLE: if (go) begin
                    cs_n   <= 1'b0;
                    sh     <= tx_word;
                    bitcnt <= '0;
                    ph     <= F_LEAD;
                end
                F_LEAD: if (tick) ph <= F_SHIFT;
                F_SHIFT: if (tick) begin
                    if (!sclk) begin
                        sclk <= 1'b1;
                        din  <= sh[WORD_W-1];
                        sh   <= {sh[WORD_W-2:0], 1'b0};
                    end else begin
                        sclk    <= 1'b0;
                        rx_word <= {rx_word[WORD_W-2:0], dout};
                        bitcnt  <= bitcnt + 1'b1;
                        if (bitcnt == BW'(WORD_W - 1)) ph <= F_TRAIL;
                    end
                end
                F_TRAIL: if (tick) begin
                    cs_n <= 1'b1;
                    din  <= 1'b0;
                    ph   <= F_GAP;
                end
                F_GAP: if (tick) begin
                    fdone <= 1'b1;
                    ph    <= F_IDLE;
                end
                default: ph <= F_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/adc_cmd_host.sv
module adc_cmd_host
    import adc_cmd_pkg::*;
#(
    parameter int CLK_DIV = 4,
    parameter int POLL_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              op_custom,
    input  logic [CODE_W-1:0] cmd_code,
    input  logic [POLL_W-1:0] poll_limit,
    output logic              busy,
    output logic              done,
    output logic              ready_ok,
    output logic              error,
    output logic [CODE_W-1:0] resp_code,
    output logic              sclk,
    output logic              cs_n,
    output logic              din,
    input  logic              dout
);
    localparam int HALF = (CLK_DIV < 2) ? 1 : CLK_DIV / 2;
    localparam logic [WORD_W-1:0] READY_WORD = {READY_CODE, {PAD_W{1'b0}}};

    host_st_t          state, state_n;
    logic              go, fdone;
    logic [WORD_W-1:0] tx_word, rx_word;
    logic              mode_q;
    logic [POLL_W-1:0] limit_q, polls;
    logic              poll_last, rx_exact, rx_code_hit, poll_frame;

    adc_frame_engine #(.HALF(HALF)) u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (go),
        .tx_word (tx_word),
        .dout    (dout),
        .sclk    (sclk),
        .cs_n    (cs_n),
        .din     (din),
        .fdone   (fdone),
        .rx_word (rx_word)
    );

    assign poll_last   = ({1'b0, polls} + 1'b1) >= {1'b0, limit_q};
    assign rx_exact    = (rx_word == READY_WORD);
    assign rx_code_hit = (rx_word[WORD_W-1:PAD_W] == READY_CODE);
    assign poll_frame  = (state == S_POLL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_n;
    end

    always_comb begin
        state_n = state;
        unique case (state)
            S_IDLE: if (start) state_n = S_CMD;
            S_CMD:  if (fdone) state_n = S_POLL;
            S_POLL: if (fdone) begin
                if (mode_q || rx_code_hit || poll_last) state_n = S_DONE;
            end
            S_DONE: state_n = S_IDLE;
            default: state_n = S_IDLE;
        endcase
    end

    always_comb begin
        busy    = (state != S_IDLE);
        done    = (state == S_DONE);
        go      = ((state == S_IDLE) && start) || ((state != S_IDLE) && (state_n != S_DONE) && fdone);
        tx_word = '0;
        if (state == S_IDLE) tx_word = op_custom ? {cmd_code, {PAD_W{1'b0}}} : {RESET_CODE, {PAD_W{1'b0}}};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ready_ok  <= 1'b0;
            error     <= 1'b0;
            resp_code <= '0;
            mode_q    <= 1'b0;
            limit_q   <= '0;
            polls     <= '0;
        end else if (state == S_IDLE && start) begin
            ready_ok  <= 1'b0;
            error     <= 1'b0;
            resp_code <= '0;
            mode_q    <= op_custom;
            limit_q   <= poll_limit;
            polls     <= '0;
        end else if (state == S_POLL && fdone) begin
            resp_code <= rx_word[WORD_W-1:PAD_W];
            polls     <= polls + 1'b1;
            if (mode_q)                    error    <= |rx_word[PAD_W-1:0];
            else if (rx_exact)             ready_ok <= 1'b1;
            else if (rx_code_hit || poll_last) error <= 1'b1;
        end
    end
endmodule

// File: rtl/adc_cmd_host_chk.sv
module adc_cmd_host_chk (
    input logic clk,
    input logic rst_n,
    input logic sclk,
    input logic cs_n,
    input logic din,
    input logic busy,
    input logic done,
    input logic ready_ok,
    input logic error,
    input logic poll_frame
);
    a_r7_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    a_r7_din_moves: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(din) |-> ($rose(sclk) || $rose(cs_n)));

    a_r8_cs_leads: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> ($past(!cs_n) && !cs_n));

    a_r2_null_poll: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_frame && !cs_n) |-> !din);

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_done_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    a_r3_flags_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(ready_ok && error));
endmodule

bind adc_cmd_host adc_cmd_host_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sclk       (sclk),
    .cs_n       (cs_n),
    .din        (din),
    .busy       (busy),
    .done       (done),
    .ready_ok   (ready_ok),
    .error      (error),
    .poll_frame (poll_frame)
);

// File: tb/adc_cmd_host_bench.sv
`timescale 1ns/1ps
module adc_cmd_host_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        op_custom = 1'b0;
    logic [15:0] cmd_code = '0;
    logic [7:0]  poll_limit = '0;
    logic        busy, done, ready_ok, error, sclk, cs_n, din;
    logic [15:0] resp_code;
    logic        dout_m = 1'b0;

    always #2.5 clk = ~clk;

    adc_cmd_host u_adc_cmd_host (
        .clk(clk), .rst_n(rst_n), .start(start), .op_custom(op_custom),
        .cmd_code(cmd_code), .poll_limit(poll_limit), .busy(busy), .done(done),
        .ready_ok(ready_ok), .error(error), .resp_code(resp_code),
        .sclk(sclk), .cs_n(cs_n), .din(din), .dout(dout_m)
    );

    // behavioural device: scripted reply per frame, collects DIN
    logic [23:0] rsp [8];
    logic [23:0] shw = '0, rxw = '0, first_word = '0;
    int          fidx = 0, nonnull = 0;
    bit          armed = 1'b0;

    always @(negedge cs_n) if (armed) shw <= (fidx < 8) ? rsp[fidx] : 24'h0;
    always @(posedge sclk) if (!cs_n) begin
        dout_m <= shw[23];
        shw    <= {shw[22:0], 1'b0};
    end
    always @(negedge sclk) if (!cs_n) rxw <= {rxw[22:0], din};
    always @(posedge cs_n) if (armed) begin
        if (fidx == 0) first_word <= rxw;
        else if (rxw != 24'h0) nonnull <= nonnull + 1;
        fidx <= fidx + 1;
    end

    int total = 0, bad = 0, cyc = 0;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    typedef struct packed {
        logic        op;
        logic [15:0] cmd;
        logic [7:0]  lim;
        logic [23:0] r1, r2, r3, r4;
        logic        e_ok, e_err;
        logic [15:0] e_resp;
        logic [3:0]  e_frames;
    } vec_t;

    localparam vec_t VEC [7] = '{
        '{1'b0, 16'h0000, 8'd4, 24'hFF0200, 24'h0, 24'h0, 24'h0, 1'b1, 1'b0, 16'hFF02, 4'd2},
        '{1'b0, 16'h0000, 8'd4, 24'h000000, 24'h123400, 24'hFF0200, 24'h0, 1'b1, 1'b0, 16'hFF02, 4'd4},
        '{1'b0, 16'h0000, 8'd4, 24'hFF0201, 24'hFF0200, 24'h0, 24'h0, 1'b0, 1'b1, 16'hFF02, 4'd2},
        '{1'b0, 16'h0000, 8'd3, 24'h000000, 24'h000100, 24'hFF0000, 24'hFF0200, 1'b0, 1'b1, 16'hFF00, 4'd4},
        '{1'b1, 16'h2A55, 8'd4, 24'hABCD00, 24'h0, 24'h0, 24'h0, 1'b0, 1'b0, 16'hABCD, 4'd2},
        '{1'b1, 16'h0600, 8'd4, 24'h1234FF, 24'h0, 24'h0, 24'h0, 1'b0, 1'b1, 16'h1234, 4'd2},
        '{1'b0, 16'h0000, 8'd0, 24'h000000, 24'hFF0200, 24'h0, 24'h0, 1'b0, 1'b1, 16'h0000, 4'd2}
    };

    task automatic launch(input logic op, input logic [15:0] cmd, input logic [7:0] lim);
        @(negedge clk);
        fidx = 0; nonnull = 0;
        op_custom = op; cmd_code = cmd; poll_limit = lim; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R9", "busy after start", busy, 1'b1);
    endtask

    task automatic wait_done(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (done) begin ok = 1'b1; break; end
        end
        chk("R9", "done seen", ok, 1'b1);
    endtask

    initial begin
        bit ok;
        for (int k = 0; k < 8; k++) rsp[k] = 24'h0;
        repeat (4) @(negedge clk);
        chk("R10", "cs_n", cs_n, 1'b1);
        chk("R10", "sclk", sclk, 1'b0);
        chk("R10", "din", din, 1'b0);
        chk("R10", "busy/done", {busy, done}, 2'b00);
        chk("R10", "flags", {ready_ok, error, resp_code}, 18'h0);
        rst_n = 1'b1;
        armed = 1'b1;
        @(negedge clk);
        chk("R10", "idle after reset", {busy, cs_n, sclk}, 3'b010);

        for (int v = 0; v < 7; v++) begin
            rsp[0] = 24'h0; rsp[1] = VEC[v].r1; rsp[2] = VEC[v].r2;
            rsp[3] = VEC[v].r3; rsp[4] = VEC[v].r4;
            launch(VEC[v].op, VEC[v].cmd, VEC[v].lim);
            wait_done(ok);
            if (ok) begin
                chk(VEC[v].op ? "R6" : "R1", "first DIN word", first_word,
                    VEC[v].op ? {VEC[v].cmd, 8'h00} : 24'h001100);
                chk("R2", "null polls", nonnull, 0);
                chk(VEC[v].op ? "R6" : (VEC[v].e_ok ? "R3" : (v == 2 ? "R4" : "R5")),
                    "ready_ok/error", {ready_ok, error}, {VEC[v].e_ok, VEC[v].e_err});
                chk(VEC[v].op ? "R6" : "R3", "resp_code", resp_code, VEC[v].e_resp);
                chk(VEC[v].op ? "R6" : "R5", "frame count", fidx, VEC[v].e_frames);
                chk("R8", "cs_n high at done", cs_n, 1'b1);
                @(negedge clk);
                chk("R9", "done one cycle", {done, busy}, 2'b00);
            end
        end

        // R9: start during a run is ignored
        rsp[1] = 24'h567800;
        launch(1'b1, 16'h1234, 8'd4);
        repeat (20) @(negedge clk);
        op_custom = 1'b0; cmd_code = 16'hFFFF; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(ok);
        chk("R9", "ignored start first word", first_word, 24'h123400);
        chk("R9", "ignored start frames", fidx, 2);
        chk("R9", "ignored start resp", resp_code, 16'h5678);
        repeat (300) @(negedge clk);
        chk("R9", "no extra frames", fidx, 2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule